// File: doc/BRIEF.md
# Two-Way Mailbox Message Unit

The block carries 32-bit messages between a remote host and a local processor. Each side has its own simple register port: a write strobe, an address and write data, plus read data that reflects the addressed register in the same cycle. The host leaves messages for the local processor in two inbound slots. The local processor leaves messages for the host in two outbound slots. Each write to a slot stores the value and sets a pending flag for that slot.

Each direction has a pending-status register and a mask register. The receiving side acknowledges a message by writing 1 to the matching status bit. A mask bit hides a pending flag from the interrupt but does not clear it. Each side has one registered level interrupt, driven by the unmasked pending flags of the messages addressed to it.

Address map, shared by both ports: 0 and 1 are the inbound slots, 2 and 3 are the outbound slots, 4 is inbound status, 5 is inbound mask, 6 is outbound status and 7 is outbound mask. Status and mask values occupy bits [1:0], where bit i refers to slot i, and the upper bits read as 0.

Top module: `mbox_msg_unit`

## Requirements
- R1: After reset, every slot and every status bit reads 0, both masks read 0 (nothing masked), and both interrupts are low.
- R2: A host write to address 0 or 1 stores the 32-bit data in inbound slot 0 or 1 and sets inbound status bit 0 or 1.
- R3: A local write to address 2 or 3 stores the data in outbound slot 0 or 1 and sets outbound status bit 0 or 1.
- R4: A local write to address 4 clears each inbound status bit whose data bit is 1. Bits written 0 keep their value.
- R5: A host write to address 6 clears each outbound status bit whose data bit is 1. Bits written 0 keep their value.
- R6: If a slot write and a write-1 clear of that slot's status bit happen in the same cycle, the status bit ends up set.
- R7: The local side writes the inbound mask (address 5) and the host writes the outbound mask (address 7). A mask bit of 1 hides that slot from the interrupt, and a mask write never changes the status.
- R8: loc_irq and host_irq are registered. In each cycle, each one equals the OR of the unmasked status bits of its direction as they stood in the previous cycle.
- R9: A write from the side that does not own a register has no effect. The host cannot write addresses 2, 3, 4 or 5, and the local side cannot write addresses 0, 1, 6 or 7.
- R10: Both ports can read every address. A slot keeps its value until its owner writes it again, and a read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| loc_wr_en | input | 1 | Local write strobe |
| loc_addr | input | 3 | Local register address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data for loc_addr |
| loc_irq | output | 1 | Interrupt toward the local processor |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
Directed cases come first. They isolate a single slot write, each side writing a register it does not own, a clear written with 0 and then with 1, a slot write and its clear landing in the same cycle, and a mask raised while a flag is pending. These cases separate a correct write-1 clear and a correct ownership check from faulty ones. They also show set-over-clear priority and that masking gates only the interrupt. A seeded random phase then drives both ports at once with random addresses and data. Status and mask writes are biased toward small values, so that partial clears and mixed masks occur often. Every cycle it compares both read ports and both interrupts with a bench model. This catches cross-talk between directions and off-by-one interrupt latency.

// File: rtl/mbox_msg_unit.sv
module mbox_msg_unit #(
  parameter int DATA_W = 32,
  parameter int NMSG   = 2,
  localparam int ADDR_W = $clog2(2*NMSG+4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              loc_wr_en,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  output logic              loc_irq,
  output logic              host_irq
);
  localparam int A_IST  = 2*NMSG;
  localparam int A_IMSK = 2*NMSG + 1;
  localparam int A_OST  = 2*NMSG + 2;
  localparam int A_OMSK = 2*NMSG + 3;

  logic [DATA_W-1:0] in_msg  [NMSG];
  logic [DATA_W-1:0] out_msg [NMSG];
  logic [NMSG-1:0]   in_stat, in_mask, out_stat, out_mask;
  logic [NMSG-1:0]   h_in_wr, l_out_wr;

  wire l_ist_wr  = loc_wr_en  && loc_addr  == ADDR_W'(A_IST);
  wire l_imsk_wr = loc_wr_en  && loc_addr  == ADDR_W'(A_IMSK);
  wire h_ost_wr  = host_wr_en && host_addr == ADDR_W'(A_OST);
  wire h_omsk_wr = host_wr_en && host_addr == ADDR_W'(A_OMSK);

  for (genvar i = 0; i < NMSG; i++) begin : g_slot
    assign h_in_wr[i]  = host_wr_en && host_addr == ADDR_W'(i);
    assign l_out_wr[i] = loc_wr_en  && loc_addr  == ADDR_W'(NMSG + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_msg[i]  <= '0;
        out_msg[i] <= '0;
      end else begin
        if (h_in_wr[i])  in_msg[i]  <= host_wdata;
        if (l_out_wr[i]) out_msg[i] <= loc_wdata;
      end
    end
  end

  wire [NMSG-1:0] in_clr  = l_ist_wr ? loc_wdata[NMSG-1:0]  : '0;
  wire [NMSG-1:0] out_clr = h_ost_wr ? host_wdata[NMSG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_stat  <= '0;
      out_stat <= '0;
      in_mask  <= '0;
      out_mask <= '0;
      loc_irq  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      in_stat  <= (in_stat  & ~in_clr)  | h_in_wr;
      out_stat <= (out_stat & ~out_clr) | l_out_wr;
      if (l_imsk_wr) in_mask  <= loc_wdata[NMSG-1:0];
      if (h_omsk_wr) out_mask <= host_wdata[NMSG-1:0];
      loc_irq  <= |(in_stat  & ~in_mask);
      host_irq <= |(out_stat & ~out_mask);
    end
  end

  function automatic logic [DATA_W-1:0] rd_mux(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < NMSG; i++) begin
      if (a == ADDR_W'(i))        v = in_msg[i];
      if (a == ADDR_W'(NMSG + i)) v = out_msg[i];
    end
    if (a == ADDR_W'(A_IST))  v = DATA_W'(in_stat);
    if (a == ADDR_W'(A_IMSK)) v = DATA_W'(in_mask);
    if (a == ADDR_W'(A_OST))  v = DATA_W'(out_stat);
    if (a == ADDR_W'(A_OMSK)) v = DATA_W'(out_mask);
    return v;
  endfunction

  assign host_rdata = rd_mux(host_addr);
  assign loc_rdata  = rd_mux(loc_addr);
endmodule

module mbox_msg_unit_chk #(
  parameter int NMSG   = 2,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic              loc_wr_en,
  input logic [ADDR_W-1:0] loc_addr,
  input logic              loc_wd0,
  input logic [NMSG-1:0]   in_stat,
  input logic [NMSG-1:0]   in_mask,
  input logic [NMSG-1:0]   out_stat,
  input logic [NMSG-1:0]   out_mask,
  input logic              loc_irq,
  input logic              host_irq
);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(2*NMSG);
  localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(2*NMSG + 1);
  localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(NMSG);

  a_r2_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_addr == '0 |=> in_stat[0]);

  a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en && loc_addr == A_OUT0 |=> out_stat[0]);

  a_r4_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en && loc_addr == A_IST && loc_wd0 && !(host_wr_en && host_addr == '0)
    |=> !in_stat[0]);

  a_r4_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_stat[0] && !(loc_wr_en && loc_addr == A_IST) |=> in_stat[0]);

  a_r9_imask_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr_en && loc_addr == A_IMSK) |=> $stable(in_mask));

  a_r8_loc_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_irq) |-> $past(|(in_stat & ~in_mask)));

  a_r8_host_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(~|(out_stat & ~out_mask)));
endmodule

bind mbox_msg_unit mbox_msg_unit_chk #(.NMSG(NMSG), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .host_wr_en(host_wr_en), .host_addr(host_addr),
  .loc_wr_en(loc_wr_en), .loc_addr(loc_addr), .loc_wd0(loc_wdata[0]),
  .in_stat(in_stat), .in_mask(in_mask), .out_stat(out_stat), .out_mask(out_mask),
  .loc_irq(loc_irq), .host_irq(host_irq)
);

// File: tb/mbox_msg_unit_tb.sv
module mbox_msg_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr_en = 1'b0, loc_wr_en = 1'b0;
  logic [2:0] host_addr = '0, loc_addr = '0;
  logic [31:0] host_wdata = '0, loc_wdata = '0, host_rdata, loc_rdata;
  logic loc_irq, host_irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_in [2];
  logic [31:0] m_out [2];
  logic [1:0] m_ist, m_imsk, m_ost, m_omsk;

  always #2 clk = ~clk;

  mbox_msg_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .loc_wr_en(loc_wr_en), .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .loc_irq(loc_irq), .host_irq(host_irq)
  );

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_in[0];
      3'd1: return m_in[1];
      3'd2: return m_out[0];
      3'd3: return m_out[1];
      3'd4: return {30'd0, m_ist};
      3'd5: return {30'd0, m_imsk};
      3'd6: return {30'd0, m_ost};
      default: return {30'd0, m_omsk};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
    m_ist = '0; m_imsk = '0; m_ost = '0; m_omsk = '0;
  endtask

  task automatic model_update(input bit hw, input logic [2:0] ha, input logic [31:0] hd,
                              input bit lw, input logic [2:0] la, input logic [31:0] ld);
    logic [1:0] iset, oset, iclr, oclr;
    iset = '0; oset = '0; iclr = '0; oclr = '0;
    if (hw) begin
      if (ha == 3'd0) begin m_in[0] = hd; iset[0] = 1'b1; end
      if (ha == 3'd1) begin m_in[1] = hd; iset[1] = 1'b1; end
      if (ha == 3'd6) oclr = hd[1:0];
      if (ha == 3'd7) m_omsk = hd[1:0];
    end
    if (lw) begin
      if (la == 3'd2) begin m_out[0] = ld; oset[0] = 1'b1; end
      if (la == 3'd3) begin m_out[1] = ld; oset[1] = 1'b1; end
      if (la == 3'd4) iclr = ld[1:0];
      if (la == 3'd5) m_imsk = ld[1:0];
    end
    m_ist = (m_ist & ~iclr) | iset;
    m_ost = (m_ost & ~oclr) | oset;
  endtask

  task automatic step(input bit hw, input logic [2:0] ha, input logic [31:0] hd,
                      input bit lw, input logic [2:0] la, input logic [31:0] ld, input string req);
    bit exp_li, exp_hi;
    @(negedge clk);
    host_wr_en = hw; host_addr = ha; host_wdata = hd;
    loc_wr_en = lw; loc_addr = la; loc_wdata = ld;
    exp_li = |(m_ist & ~m_imsk);
    exp_hi = |(m_ost & ~m_omsk);
    @(posedge clk);
    model_update(hw, ha, hd, lw, la, ld);
    #1;
    check(loc_irq == exp_li, "R8 loc_irq", 32'(loc_irq), 32'(exp_li));
    check(host_irq == exp_hi, "R8 host_irq", 32'(host_irq), 32'(exp_hi));
    check(host_rdata == model_rd(ha), {req, " host_rdata"}, host_rdata, model_rd(ha));
    check(loc_rdata == model_rd(la), {req, " loc_rdata"}, loc_rdata, model_rd(la));
    host_wr_en = 1'b0; loc_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [2:0] ha, la;
    logic [31:0] hd, ld;
    void'($urandom(32'h5EED_2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(loc_irq == 1'b0 && host_irq == 1'b0, "R1 irqs", {30'd0, loc_irq, host_irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) step(0, 3'(a), '0, 0, 3'(7 - a), '0, "R1 reset value");

    step(1, 3'd0, 32'hCAFE_0001, 0, 3'd0, '0, "R2 inbound write");
    step(0, 3'd4, '0, 0, 3'd0, '0, "R10 reread");
    step(1, 3'd1, 32'h1234_5678, 0, 3'd4, '0, "R2 inbound slot1");
    step(1, 3'd2, 32'hDEAD_BEEF, 1, 3'd0, 32'h0BAD_0BAD, "R9 wrong side slot");
    step(1, 3'd4, 32'h3, 1, 3'd6, 32'h3, "R9 wrong side status");
    step(1, 3'd5, 32'h3, 1, 3'd7, 32'h3, "R9 wrong side mask");
    step(0, 3'd5, '0, 1, 3'd4, 32'h0, "R4 write zero keeps");
    step(0, 3'd0, '0, 1, 3'd4, 32'h1, "R4 clear bit0");
    step(1, 3'd1, 32'hAAAA_5555, 1, 3'd4, 32'h2, "R6 set wins over clear");
    step(0, 3'd1, '0, 1, 3'd5, 32'h2, "R7 mask slot1");
    step(0, 3'd4, '0, 0, 3'd4, '0, "R7 status kept under mask");
    step(0, 3'd4, '0, 1, 3'd5, 32'h0, "R7 unmask");
    step(0, 3'd0, '0, 1, 3'd4, 32'h3, "R4 clear all");
    step(0, 3'd2, '0, 1, 3'd3, 32'h7777_0003, "R3 outbound write");
    step(0, 3'd6, '0, 0, 3'd3, '0, "R10 outbound reread");
    step(1, 3'd6, 32'h0, 1, 3'd2, 32'h7777_0002, "R5 write zero keeps");
    step(1, 3'd6, 32'h2, 0, 3'd6, '0, "R5 clear bit1");
    step(1, 3'd6, 32'h1, 1, 3'd2, 32'h7777_0022, "R6 outbound set wins");
    step(1, 3'd7, 32'h1, 0, 3'd7, '0, "R7 host mask");
    step(1, 3'd6, 32'h1, 0, 3'd6, '0, "R5 clear masked");
    step(0, 3'd0, '0, 0, 3'd0, '0, "R10 slot persists");

    for (int n = 0; n < 4000; n++) begin
      ha = 3'($urandom_range(0, 7));
      la = 3'($urandom_range(0, 7));
      hd = (ha >= 3'd4) ? 32'($urandom_range(0, 3)) : $urandom();
      ld = (la >= 3'd4) ? 32'($urandom_range(0, 3)) : $urandom();
      step($urandom_range(0, 2) != 0, ha, hd, $urandom_range(0, 2) != 0, la, ld, "R10 random");
    end
    done = 1'b1;
    finish_run();
  end
endmodule